// File: doc/BRIEF.md
# Clock Interrupt Cause and Mask Register

This block gathers the interrupt sources of a time-of-day clock into one byte-wide register that a host reaches over a simple strobe bus. Seven sources feed it: rollover strobes for the day, hour, minute, second, tenth-second and hundredth-second counters, plus a strobe from the alarm comparator. The counters and the comparator sit outside this block. Each strobe is a single-cycle pulse on its own bit of `evt_i`.

The status address has two meanings. A write to it loads the per-source enable mask. A read from it returns every latched cause together with a summary "something pending" bit, and the same read clears the latched causes. A separate global enable bit lives in the command address. The active-high `irq_o` line rises when the global enable is set and at least one enabled cause is latched. It stays high until the causes are read. When only the hundredth-second source is enabled and the host reads once per interrupt, the line fires once per hundredth-second strobe, which gives 100 interrupts per second.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the enable mask, the latched causes, the global enable, `irq_o` and `host_rdata` are all zero.
- R2: A write (`host_sel`=1, `host_wr`=1) to address 16 loads `host_wdata[6:0]` as the enable mask. Bit 7 of the written byte has no effect.
- R3: A strobe on `evt_i[k]` latches cause bit k only if mask bit k is set. Strobes on sources that are masked off leave the cause register unchanged.
- R4: A read (`host_sel`=1, `host_wr`=0) of address 16 places a byte on `host_rdata` from the next cycle on. Bit 7 is the OR of all latched causes. Bits 6..0 are the latched causes: 6 day, 5 hour, 4 minute, 3 second, 2 tenth-second, 1 hundredth-second, 0 alarm. `host_rdata` holds this value until the next read.
- R5: A read of address 16 clears every latched cause, so an immediate second read with no new strobes returns 0.
- R6: An enabled strobe that arrives in the same cycle as a clearing read does not appear in that read's data. It remains latched for the following read.
- R7: Several causes, the alarm included, can be latched and reported together in one read.
- R8: A write to address 17 takes bit 4 as the global interrupt enable. The other bits of that byte do not affect `irq_o`.
- R9: `irq_o` is registered. In the cycle after any state change it equals global enable AND (any cause that is latched and whose mask bit is set). It stays high until a read clears the causes, the mask, or the global enable.
- R10: A read of any address other than 16 returns 0 on `host_rdata` and does not clear the causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read for the current access |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data captured on the access cycle |
| evt_i | input | 7 | Source strobes, bit order as in R4 |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
A cause flag that is set or cleared wrongly shows up on `irq_o` in the very next cycle, as long as its mask bit and the global enable are set. Otherwise it appears in the data of the next status read, where the summary bit has to agree with the cause bits. A mask or enable register that captured the wrong value does not show directly. It appears only when a later strobe fails to latch, or latches when it should not. For that reason the stimulus keeps rewriting both registers while strobes keep arriving. Checking a read one cycle after it is issued also catches a clear that fires on the wrong address or drops a strobe that collides with the read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  // Decoded host operation for one access cycle
  typedef struct packed {
    logic wr_mask;   // write of the status/mask address
    logic wr_cmd;    // write of the command address
    logic rd_stat;   // clearing read of the status address
    logic rd_other;  // read of any other address
  } host_op_t;

endpackage

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned STAT_OFS = 16,
  parameter int unsigned CMD_OFS  = 17
) (
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output host_op_t          op
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);

  logic hit_stat;
  logic hit_cmd;

  always_comb begin
    hit_stat    = (host_addr == STAT_A);
    hit_cmd     = (host_addr == CMD_A);
    op.wr_mask  = host_sel &  host_wr & hit_stat;
    op.wr_cmd   = host_sel &  host_wr & hit_cmd;
    op.rd_stat  = host_sel & ~host_wr & hit_stat;
    op.rd_other = host_sel & ~host_wr & ~hit_stat;
  end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SRC_N   = 7,
  parameter int unsigned GIE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_op_t          op,
  input  logic [DATA_W-1:0] wdata,
  output logic [SRC_N-1:0]  mask_q,
  output logic [SRC_N-1:0]  mask_d,
  output logic              gie_q,
  output logic              gie_d
);

  logic mask_en;
  logic gie_en;

  // Next state: load only on a decoded write
  always_comb begin
    mask_en = op.wr_mask;
    gie_en  = op.wr_cmd;
    mask_d  = mask_en ? wdata[SRC_N-1:0] : mask_q;
    gie_d   = gie_en  ? wdata[GIE_BIT]   : gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (gie_en)  gie_q  <= gie_d;
    end
  end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] mask_q,
  output logic [SRC_N-1:0] flag_q,
  output logic [SRC_N-1:0] flag_d
);

  // One sticky cell per source; a strobe on the clearing cycle wins
  for (genvar k = 0; k < SRC_N; k++) begin : g_cell
    logic set_k;
    logic en_k;

    always_comb begin
      set_k     = evt[k] & mask_q[k];
      en_k      = clr | set_k;
      flag_d[k] = set_k | (flag_q[k] & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q[k] <= 1'b0;
      else if (en_k) flag_q[k] <= flag_d[k];
    end
  end

endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_N  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_op_t          op,
  input  logic [SRC_N-1:0]  flag_q,
  input  logic [SRC_N-1:0]  flag_d,
  input  logic [SRC_N-1:0]  mask_d,
  input  logic              gie_d,
  output logic [DATA_W-1:0] rdata_q,
  output logic              irq_q
);

  localparam int unsigned ANY_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - 1 - SRC_N;

  logic              rd_en;
  logic [DATA_W-1:0] rdata_d;
  logic              irq_d;

  always_comb begin
    rd_en   = op.rd_stat | op.rd_other;
    rdata_d = '0;
    if (op.rd_stat) begin
      rdata_d[SRC_N-1:0] = flag_q;
      rdata_d[ANY_BIT]   = |flag_q;
    end
    irq_d = gie_d & |(flag_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      irq_q <= irq_d;
    end
  end

  if (PAD_W > DATA_W) begin : g_bad_width
    initial $error("SRC_N must be below DATA_W");
  end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SRC_N    = 7,
  parameter int unsigned STAT_OFS = 16,
  parameter int unsigned CMD_OFS  = 17,
  parameter int unsigned GIE_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [SRC_N-1:0]  evt_i,
  output logic              irq_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  host_op_t         op;
  logic [SRC_N-1:0] mask_q, mask_d;
  logic             gie_q, gie_d;
  logic [SRC_N-1:0] flag_q, flag_d;

  rtc_irq_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CMD_OFS(CMD_OFS)
  ) u_decode (
    .host_sel (host_sel),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .op       (op)
  );

  rtc_irq_regs #(
    .DATA_W(DATA_W), .SRC_N(SRC_N), .GIE_BIT(GIE_BIT)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .op    (op),
    .wdata (host_wdata),
    .mask_q(mask_q),
    .mask_d(mask_d),
    .gie_q (gie_q),
    .gie_d (gie_d)
  );

  rtc_irq_flags #(.SRC_N(SRC_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (op.rd_stat),
    .evt   (evt_i),
    .mask_q(mask_q),
    .flag_q(flag_q),
    .flag_d(flag_d)
  );

  rtc_irq_out #(.DATA_W(DATA_W), .SRC_N(SRC_N)) u_out (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .op     (op),
    .flag_q (flag_q),
    .flag_d (flag_d),
    .mask_d (mask_d),
    .gie_d  (gie_d),
    .rdata_q(host_rdata),
    .irq_q  (irq_o)
  );

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SRC_N    = 7,
  parameter int unsigned STAT_OFS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [SRC_N-1:0]  evt_i,
  input logic [SRC_N-1:0]  mask_q,
  input logic [SRC_N-1:0]  flag_q,
  input logic [DATA_W-1:0] host_rdata,
  input logic              irq_o
);

  logic rd_stat;
  logic rd_other;
  assign rd_stat  = host_sel & ~host_wr & (host_addr == ADDR_W'(STAT_OFS));
  assign rd_other = host_sel & ~host_wr & (host_addr != ADDR_W'(STAT_OFS));

  // R3: a cause bit only appears when its source strobed while enabled
  p_masked_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i & mask_q)) == '0));

  // R4: read data equals the causes held on the access cycle
  p_rdata_causes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (host_rdata[SRC_N-1:0] == $past(flag_q)));

  p_rdata_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (host_rdata[DATA_W-1] == ($past(flag_q) != '0)));

  // R5/R6: after a clearing read only colliding enabled strobes survive
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> ((flag_q & ~$past(evt_i & mask_q)) == '0));

  // R9: with no host access the request cannot drop
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !host_sel) |=> irq_o);

  // R10: reads elsewhere return zero and keep the causes
  p_other_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> (host_rdata == '0 && (($past(flag_q) & ~flag_q) == '0)));

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_N(SRC_N), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .host_sel  (host_sel),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .evt_i     (evt_i),
  .mask_q    (mask_q),
  .flag_q    (flag_q),
  .host_rdata(host_rdata),
  .irq_o     (irq_o)
);

// File: tb/rtc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_tb_top;

  logic       clk;
  logic       rst_n;
  logic       host_sel;
  logic       host_wr;
  logic [4:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [6:0] evt_i;
  logic       irq_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // reference state
  logic [6:0] m_mask, m_flags;
  logic       m_gie, m_irq;
  logic [7:0] m_rdata;

  rtc_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic [6:0] f);
    return {|f, f};
  endfunction

  // one bus cycle: drive at negedge, update model at posedge, compare after
  task automatic step(input bit sel, input bit wr, input logic [4:0] addr,
                      input logic [7:0] wd, input logic [6:0] ev);
    bit rd;
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd; evt_i = ev;
    @(posedge clk);
    rd = sel && !wr && addr == 5'd16;
    if (rd) m_rdata = stat_byte(m_flags);
    else if (sel && !wr) m_rdata = 8'h00;
    m_flags = (rd ? 7'h00 : m_flags) | (ev & m_mask);
    if (sel && wr && addr == 5'd16) m_mask = wd[6:0];
    if (sel && wr && addr == 5'd17) m_gie  = wd[4];
    m_irq = m_gie & |(m_flags & m_mask);
    #1;
    check(irq_o === m_irq, "R9 irq", {7'h0, irq_o}, {7'h0, m_irq});
    check(host_rdata === m_rdata, "R4 rdata", host_rdata, m_rdata);
  endtask

  task automatic idle(); step(0, 0, 5'd0, 8'h00, 7'h00); endtask
  task automatic rd(input logic [4:0] a, input logic [6:0] ev);
    step(1, 0, a, 8'h00, ev);
  endtask
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    step(1, 1, a, d, 7'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rises;
    void'($urandom(32'd5171));
    host_sel = 0; host_wr = 0; host_addr = '0; host_wdata = '0; evt_i = '0;
    m_mask = '0; m_flags = '0; m_gie = 0; m_irq = 0; m_rdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(irq_o === 1'b0, "R1 irq after reset", {7'h0, irq_o}, 8'h00);
    check(host_rdata === 8'h00, "R1 rdata after reset", host_rdata, 8'h00);
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'h00, "R1 causes empty", host_rdata, 8'h00);

    // R2 R3: bit 7 of mask ignored; masked sources dropped
    wr(5'd16, 8'h82); wr(5'd17, 8'h10);
    step(0, 0, 5'd0, 8'h00, 7'h7F); idle();
    check(irq_o === 1'b1, "R9 irq on enabled cause", {7'h0, irq_o}, 8'h01);
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'h82, "R3 only enabled cause latched", host_rdata, 8'h82);
    check(irq_o === 1'b0, "R9 irq cleared by read", {7'h0, irq_o}, 8'h00);
    // R5 second read empty
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'h00, "R5 second read empty", host_rdata, 8'h00);

    // R7 simultaneous causes incl. alarm
    wr(5'd16, 8'h7F);
    step(0, 0, 5'd0, 8'h00, 7'h41); idle();
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'hC1, "R7 day and alarm together", host_rdata, 8'hC1);

    // R6 strobe colliding with a clearing read
    step(0, 0, 5'd0, 8'h00, 7'h08);
    rd(5'd16, 7'h10); idle();
    check(host_rdata === 8'h88, "R6 collided strobe not in this read", host_rdata, 8'h88);
    check(irq_o === 1'b1, "R6 collided strobe keeps irq", {7'h0, irq_o}, 8'h01);
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'h90, "R6 collided strobe in next read", host_rdata, 8'h90);

    // R8 global enable
    step(0, 0, 5'd0, 8'h00, 7'h04);
    wr(5'd17, 8'hEF); idle();
    check(irq_o === 1'b0, "R8 enable bit clear blocks irq", {7'h0, irq_o}, 8'h00);
    wr(5'd17, 8'h10); idle();
    check(irq_o === 1'b1, "R8 enable bit set raises irq", {7'h0, irq_o}, 8'h01);

    // R10 other address read, R9 hold
    rd(5'd3, 7'h00); idle(); idle(); idle();
    check(host_rdata === 8'h00, "R10 other address reads zero", host_rdata, 8'h00);
    check(irq_o === 1'b1, "R10 other read keeps cause", {7'h0, irq_o}, 8'h01);
    rd(5'd16, 7'h00); idle();
    check(host_rdata === 8'h84, "R10 cause survived", host_rdata, 8'h84);

    // R9 hundredth-only: one request per strobe
    wr(5'd16, 8'h02); rises = 0;
    for (int i = 0; i < 100; i++) begin
      step(0, 0, 5'd0, 8'h00, 7'h02);
      if (irq_o) rises++;
      rd(5'd16, 7'h00);
    end
    check(rises == 100, "R9 hundredth rate", 8'(rises), 8'd100);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned a = $urandom_range(9, 0);
      logic [6:0] ev = 7'($urandom) & 7'($urandom) & 7'($urandom);
      logic [7:0] d  = 8'($urandom);
      if (a < 2)       step(1, 0, 5'd16, 8'h00, ev);
      else if (a == 2) step(1, 1, 5'd16, d, ev);
      else if (a == 3) step(1, 1, 5'd17, d | ($urandom_range(3, 0) != 0 ? 8'h10 : 8'h00), ev);
      else if (a == 4) step(1, $urandom_range(1, 0) == 1, 5'($urandom), d, ev);
      else             step(0, 0, 5'd0, 8'h00, ev);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule